// File: doc/BRIEF.md
# Branch Target Buffer with Return Stack

This block predicts the next fetch address in the fetch stage. It holds a direct-mapped table of full branch targets, tagged with the upper PC bits, and a small return stack for procedure calls. In each cycle it takes the fetch PC, a taken/not-taken hint from a separate direction predictor, and flags marking the fetched instruction as a call or a return. It returns the address to fetch next.

Resolved branches come back through an update port, which carries the branch PC and its real target. The table entry is rewritten only when the real target differs from what the table would have predicted for that PC. Calls push the address of the following instruction. Returns pop that address and use it in place of the table. Direction prediction, decode and flush recovery are left to the surrounding pipeline.

Top module: `btb_ras_predictor`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty, so `next_pc_o` is `fetch_pc_i + 4` and `btb_hit_o` is 0 for any hint or return flag.
- R2: The table index is PC bits [9:2] (256 entries) and the tag is bits [31:10]; PC bits [1:0] do not take part in the lookup.
- R3: A valid entry whose stored tag differs from fetch PC bits [31:10] gives no hit, and `next_pc_o` is `fetch_pc_i + 4`.
- R4: On a hit, a taken hint (`taken_hint_i` = 1) selects the stored target; a not-taken hint selects `fetch_pc_i + 4`.
- R5: An update whose target differs from the table's prediction for `upd_pc_i` (or that misses) writes tag, target and valid. From the next cycle, a lookup of that PC hits with the new target, and an aliasing PC loses its entry.
- R6: An update whose PC hits with a stored target equal to `upd_target_i` leaves the entry unchanged.
- R7: A call (`is_call_i` = 1) pushes `fetch_pc_i + 4`. Returns yield the pushed values in last-in first-out order.
- R8: A return with an empty stack predicts `fetch_pc_i + 4`, even when the table hits with a taken hint, and it leaves the stack empty.
- R9: The stack holds 8 entries. A push on a full stack overwrites the oldest entry, so after more than 8 calls only the 8 most recent can be returned, and the stack is then empty.
- R10: A return with a non-empty stack uses the stack top ahead of any table hit.
- R11: When call and return are both set, only the return acts; nothing is pushed.
- R12: A lookup reads the table as it stood before an update in the same cycle; the update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | Current fetch address |
| taken_hint_i | input | 1 | Direction hint, 1 = taken |
| is_call_i | input | 1 | Fetched instruction is a call |
| is_return_i | input | 1 | Fetched instruction is a return |
| upd_valid_i | input | 1 | Resolved branch update present |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_target_i | input | 32 | Resolved target |
| next_pc_o | output | 32 | Predicted next fetch address |
| btb_hit_o | output | 1 | Table tag hit for fetch_pc_i |

## Verification
On every cycle the embedded properties check the selection priority (stack over table over sequential), the empty-return fallback, the bound and the increment of the stack occupancy, and that a table write lands the resolved tag and target. Only the bench's scenarios can show the full behaviour over time. These cover aliasing eviction through the tag, the ignored low PC bits, last-in first-out order across many calls, the loss of the oldest entries after overflow, the same-cycle read-before-write of the table, and a long mixed stream compared against a behavioural model.

// File: rtl/btb_ras_pkg.sv
package btb_ras_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BTB = 2'd1,
    SRC_RAS = 2'd2
  } npc_src_e;
endpackage

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned OFF_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic [PC_W-1:0] lk_tgt_o,
  input  logic            wr_valid_i,
  input  logic [PC_W-1:0] wr_pc_i,
  input  logic [PC_W-1:0] wr_tgt_i
);
  localparam int unsigned TAG_W   = PC_W - IDX_W - OFF_W;
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  logic             wr_hit, wr_same, wr_en;
  logic             unused_lo;

  assign lk_idx = lk_pc_i[OFF_W +: IDX_W];
  assign lk_tag = lk_pc_i[PC_W-1 -: TAG_W];
  assign wr_idx = wr_pc_i[OFF_W +: IDX_W];
  assign wr_tag = wr_pc_i[PC_W-1 -: TAG_W];
  assign unused_lo = ^{lk_pc_i[OFF_W-1:0], wr_pc_i[OFF_W-1:0]};

  assign lk_hit_o = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_tgt_o = tgt_q[lk_idx];

  // write only when the stored prediction would have been wrong
  assign wr_hit  = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
  assign wr_same = wr_hit && (tgt_q[wr_idx] == wr_tgt_i);
  assign wr_en   = wr_valid_i && !wr_same;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt_i;
    end
  end

  // R5
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
                   && tgt_q[$past(wr_idx)] == $past(wr_tgt_i));

  // R6
  same_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_same) |=> $stable(vld_q));
endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [PC_W-1:0] push_val_i,
  input  logic            pop_i,
  output logic [PC_W-1:0] top_o,
  output logic            empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  stk_q [DEPTH];
  logic [PTR_W-1:0] sp_q, sp_prev, sp_next;
  logic [CNT_W-1:0] cnt_q;
  logic             do_pop, do_push, full;

  assign sp_prev = (sp_q == '0) ? PTR_W'(DEPTH - 1) : sp_q - PTR_W'(1);
  assign sp_next = (sp_q == PTR_W'(DEPTH - 1)) ? '0 : sp_q + PTR_W'(1);
  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign top_o   = stk_q[sp_prev];

  // return beats call; pop on empty is dropped
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && !pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
    end else if (do_pop) begin
      sp_q  <= sp_prev;
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (do_push) begin
      sp_q  <= sp_next;
      if (!full) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) stk_q[sp_q] <= push_val_i;
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R7
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R7
  push_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> top_o == $past(push_val_i));

  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> empty_o && $stable(sp_q));
endmodule

// File: rtl/npc_select.sv
module npc_select
  import btb_ras_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic            [PC_W-1:0] pc_i,
  input  logic                       is_ret_i,
  input  logic                       ras_empty_i,
  input  logic            [PC_W-1:0] ras_top_i,
  input  logic                       btb_hit_i,
  input  logic            [PC_W-1:0] btb_tgt_i,
  input  logic                       taken_i,
  output npc_src_e                   src_o,
  output logic            [PC_W-1:0] npc_o
);
  always_comb begin
    if (is_ret_i && !ras_empty_i)  src_o = SRC_RAS;
    else if (is_ret_i)             src_o = SRC_SEQ;
    else if (btb_hit_i && taken_i) src_o = SRC_BTB;
    else                           src_o = SRC_SEQ;
  end

  always_comb begin
    unique case (src_o)
      SRC_RAS: npc_o = ras_top_i;
      SRC_BTB: npc_o = btb_tgt_i;
      default: npc_o = pc_i + PC_W'(4);
    endcase
  end
endmodule

// File: rtl/btb_ras_predictor.sv
module btb_ras_predictor
  import btb_ras_pkg::*;
#(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned RAS_DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic            taken_hint_i,
  input  logic            is_call_i,
  input  logic            is_return_i,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic [PC_W-1:0] upd_target_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            btb_hit_o
);
  localparam int unsigned OFF_W = 2;

  logic [PC_W-1:0] btb_tgt, ras_top, seq_pc;
  logic            btb_hit, ras_empty;
  npc_src_e        src;

  assign seq_pc = fetch_pc_i + PC_W'(4);

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_pc_i    (fetch_pc_i),
    .lk_hit_o   (btb_hit),
    .lk_tgt_o   (btb_tgt),
    .wr_valid_i (upd_valid_i),
    .wr_pc_i    (upd_pc_i),
    .wr_tgt_i   (upd_target_i)
  );

  ras_stack #(.PC_W(PC_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (is_call_i),
    .push_val_i (seq_pc),
    .pop_i      (is_return_i),
    .top_o      (ras_top),
    .empty_o    (ras_empty)
  );

  npc_select #(.PC_W(PC_W)) u_sel (
    .pc_i        (fetch_pc_i),
    .is_ret_i    (is_return_i),
    .ras_empty_i (ras_empty),
    .ras_top_i   (ras_top),
    .btb_hit_i   (btb_hit),
    .btb_tgt_i   (btb_tgt),
    .taken_i     (taken_hint_i),
    .src_o       (src),
    .npc_o       (next_pc_o)
  );

  assign btb_hit_o = btb_hit;

  // R10
  ras_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_return_i && !ras_empty) |-> next_pc_o == ras_top);

  // R4
  btb_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_return_i && btb_hit && taken_hint_i) |-> next_pc_o == btb_tgt);

  // R8
  ret_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_return_i && ras_empty) |-> next_pc_o == fetch_pc_i + PC_W'(4));

  // R4
  not_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_return_i && !taken_hint_i) |-> next_pc_o == fetch_pc_i + PC_W'(4));
endmodule

// File: tb/tb_btb_ras_predictor.sv
`timescale 1ns/1ps
module tb_btb_ras_predictor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc, upd_pc, upd_tgt;
  logic        hint, call, ret, upd_v;
  logic [31:0] next_pc;
  logic        hit;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  btb_ras_predictor dut (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc), .taken_hint_i(hint),
    .is_call_i(call), .is_return_i(ret), .upd_valid_i(upd_v), .upd_pc_i(upd_pc),
    .upd_target_i(upd_tgt), .next_pc_o(next_pc), .btb_hit_o(hit)
  );

  // behavioural reference
  bit          m_v   [int];
  logic [21:0] m_tag [int];
  logic [31:0] m_tgt [int];
  logic [31:0] m_stk [$];

  task automatic step(input logic [31:0] pc, input bit h, input bit c, input bit r,
                      input bit uv, input logic [31:0] upc, input logic [31:0] ut,
                      input string req);
    int idx, uidx;
    bit exp_hit, uhit;
    logic [31:0] exp_pc;
    @(negedge clk);
    fetch_pc = pc; hint = h; call = c; ret = r;
    upd_v = uv; upd_pc = upc; upd_tgt = ut;
    #1;
    idx = int'(pc[9:2]);
    exp_hit = m_v.exists(idx) && m_tag[idx] == pc[31:10];
    if (r && m_stk.size() > 0) exp_pc = m_stk[$];
    else if (!r && exp_hit && h) exp_pc = m_tgt[idx];
    else exp_pc = pc + 32'd4;
    vectors++;
    if (next_pc !== exp_pc || hit !== exp_hit) begin
      fails++;
      $display("FAIL %s: pc=%h next_pc=%h hit=%b expected next_pc=%h hit=%b",
               req, pc, next_pc, hit, exp_pc, exp_hit);
    end
    // state change at the coming edge
    if (r) begin
      if (m_stk.size() > 0) void'(m_stk.pop_back());
    end else if (c) begin
      m_stk.push_back(pc + 32'd4);
      if (m_stk.size() > 8) void'(m_stk.pop_front());
    end
    if (uv) begin
      uidx = int'(upc[9:2]);
      uhit = m_v.exists(uidx) && m_tag[uidx] == upc[31:10];
      if (!(uhit && m_tgt[uidx] == ut)) begin
        m_v[uidx] = 1'b1; m_tag[uidx] = upc[31:10]; m_tgt[uidx] = ut;
      end
    end
  endtask

  task automatic look(input logic [31:0] pc, input bit h, input string req);
    step(pc, h, 0, 0, 0, 32'h0, 32'h0, req);
  endtask

  task automatic upd(input logic [31:0] pc, input logic [31:0] t, input string req);
    step(32'h7000_0000, 0, 0, 0, 1, pc, t, req);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    fetch_pc = 0; hint = 0; call = 0; ret = 0; upd_v = 0; upd_pc = 0; upd_tgt = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: empty after reset
    look(32'h0000_1234, 1, "R1");
    look(32'h8000_03fc, 1, "R1");
    step(32'h0000_0100, 1, 0, 1, 0, 0, 0, "R1 R8");

    // R5 R4: install and use
    upd(32'h0000_1234, 32'h0000_8000, "R5");
    look(32'h0000_1234, 1, "R4 R5");
    look(32'h0000_1234, 0, "R4");
    // R2: low bits ignored
    look(32'h0000_1235, 1, "R2");
    look(32'h0000_1237, 1, "R2");
    // R3: alias with different tag
    look(32'h0000_1634, 1, "R3");
    look(32'h8000_1234, 1, "R3");
    // R6: same target leaves entry
    upd(32'h0000_1234, 32'h0000_8000, "R6");
    look(32'h0000_1234, 1, "R6");
    // R5: retarget, then alias eviction
    upd(32'h0000_1234, 32'h0000_9000, "R5");
    look(32'h0000_1234, 1, "R5");
    upd(32'h0000_1634, 32'h0000_a000, "R5");
    look(32'h0000_1634, 1, "R5");
    look(32'h0000_1234, 1, "R3 R5");

    // R12: same-cycle update invisible until next cycle
    step(32'h0000_2040, 1, 0, 0, 1, 32'h0000_2040, 32'h0000_3000, "R12");
    look(32'h0000_2040, 1, "R12");

    // R7: LIFO
    step(32'h0000_0400, 0, 1, 0, 0, 0, 0, "R7");
    step(32'h0000_0500, 0, 1, 0, 0, 0, 0, "R7");
    step(32'h0000_0600, 0, 1, 0, 0, 0, 0, "R7");
    // R10: return beats a taken hit
    step(32'h0000_2040, 1, 0, 1, 0, 0, 0, "R10 R7");
    step(32'h0000_0000, 0, 0, 1, 0, 0, 0, "R7");
    step(32'h0000_0000, 0, 0, 1, 0, 0, 0, "R7");
    // R8: empty return ignores taken hit
    step(32'h0000_2040, 1, 0, 1, 0, 0, 0, "R8");
    step(32'h0000_2040, 1, 0, 0, 0, 0, 0, "R8");

    // R9: overflow wraps onto oldest
    for (int i = 0; i < 11; i++)
      step(32'h0001_0000 + 32'(i) * 32'h10, 0, 1, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 10; i++)
      step(32'h0000_0800, 0, 0, 1, 0, 0, 0, "R9");

    // R11: call and return together pop only
    step(32'h0000_0900, 0, 1, 0, 0, 0, 0, "R11");
    step(32'h0000_0a00, 0, 1, 1, 0, 0, 0, "R11");
    step(32'h0000_0b00, 0, 0, 1, 0, 0, 0, "R11");

    // mixed stream against the model
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] p, u, t;
      bit cc, rr;
      p = 32'h4000_0000 | (32'($urandom % 2) << 10) | (32'($urandom % 8) << 2) | 32'($urandom % 4);
      u = 32'h4000_0000 | (32'($urandom % 2) << 10) | (32'($urandom % 8) << 2);
      t = 32'h5000_0000 + (32'($urandom % 4) << 4);
      cc = ($urandom % 6) == 0;
      rr = ($urandom % 6) == 0;
      step(p, bit'($urandom % 2), cc, rr, bit'($urandom % 3 == 0), u, t, "R4 R5 R6 R7 R12");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule